// File: doc/BRIEF.md
# Far-End Fault Signalling Unit

This block carries link-failure information in-band on a 100 Mb/s fiber link that has no auto-negotiation. It works on a serial, NRZI-level bit stream at one bit per clock. The bit rate is 125 Mb/s, and scrambling and MLT-3 coding are bypassed in this mode. On the transmit side it passes the coded stream through unchanged while the link is healthy. When the local link is down it replaces the stream with a fault pattern. The pattern repeats a cycle of 84 ones closed by one zero, 85 bits in all.

On the receive side a monitor scans the incoming stream at all times. Once it has confirmed the pattern, it pulls the local link status low. The local transmitter then signals a fault to its peer in turn.

Signal detect can come from one of three sources: a dedicated pin, an activity flag derived elsewhere, or a manual override bit. A single enable turns fiber handling on. While the enable is clear, the fault logic is idle and the transmit stream passes straight through.

Top module: `farend_fault_unit`

## Requirements
- R1: While `rstN` is low at a clock edge, `faultDetected`, `linkStatus`, `txFaultActive` and `txDataOut` all read 0 after that edge.
- R2: `sdSel` picks the signal-detect source: 1 selects `sdAuto`, 2 selects `sdManual`, and 0 or 3 select `sdPin`. Sources that are not selected have no effect on `linkStatus` or on the transmit stream.
- R3: With `fiberEn` high, `linkStatus` becomes, one clock later, `linkIn` AND the selected signal detect AND NOT `faultDetected`.
- R4: With `fiberEn` high, `txFaultActive` rises one clock after `linkStatus` reads 0. From the following clock, `txDataOut` repeats 84 ones then one zero for as long as `linkStatus` stays low.
- R5: When the link recovers, the current 85-bit cycle is completed. `txFaultActive` falls on the clock that emits the closing zero, and pass-through resumes on the next clock.
- R6: While `txFaultActive` is low, `txDataOut` equals `txDataIn` delayed by one clock.
- R7: `faultDetected` rises on the clock that samples the closing zero of the third consecutive complete cycle, each cycle being exactly 84 ones followed by a zero.
- R8: A received zero that follows fewer than 84 ones clears `faultDetected` on the clock that samples it. The confirmation count restarts.
- R9: A received run of 85 or more ones clears `faultDetected` on the clock that samples the 85th one.
- R10: A detected fault drops `linkStatus` one clock later, and `txFaultActive` rises one clock after that.
- R11: With `fiberEn` low, `faultDetected` stays 0, the transmitter only passes data through, and `linkStatus` follows `linkIn` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rstN | input | 1 | Synchronous active-low reset |
| fiberEn | input | 1 | Enables fiber fault handling |
| sdSel | input | 2 | Signal-detect source: 0/3 pin, 1 activity, 2 manual |
| sdPin | input | 1 | Signal detect from the optical module pin |
| sdAuto | input | 1 | Internally derived line-activity flag |
| sdManual | input | 1 | Manual signal-detect override bit |
| linkIn | input | 1 | Link verdict of the receive-path link monitor |
| txDataIn | input | 1 | Coded transmit bit from the encoder |
| rxDataIn | input | 1 | Received NRZI-level bit |
| txDataOut | output | 1 | Transmit bit toward the optical module |
| txFaultActive | output | 1 | Fault pattern is being sent |
| faultDetected | output | 1 | Peer fault pattern confirmed |
| linkStatus | output | 1 | Local link status |

## Verification
The receive monitor is first given three clean cycles, which separates "confirmed" from "seen once or twice". It is then given a misplaced zero at every possible position from 0 to 83 ones, which shows that no early zero can keep the fault alive. A run of 85 ones shows that over-length runs clear the fault. The transmitter is driven down once through each signal-detect source and once through `linkIn`. During each of these runs the bench compares every emitted bit with the 85-bit pattern. Each run lifts the fault mid-cycle and checks that the cycle is completed. Pseudo-random transmit data, together with a disabled-mode run fed the fault pattern, separates pass-through from pattern output.

// File: rtl/farend_fault_pkg.sv
package farend_fault_pkg;

  typedef enum logic [1:0] {
    SD_PIN     = 2'd0,
    SD_ACT     = 2'd1,
    SD_MAN     = 2'd2,
    SD_PIN_ALT = 2'd3
  } sdSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txReq;   // request fault pattern on transmit
    logic detEn;   // receive monitor enabled
  } faultStrobe_t;

endpackage

// File: rtl/farend_fault_ctrl.sv
module farend_fault_ctrl
  import farend_fault_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fiberEn,
  input  logic [1:0]   sdSel,
  input  logic         sdPin,
  input  logic         sdAuto,
  input  logic         sdManual,
  input  logic         linkIn,
  input  logic         faultSeen,
  output logic         linkStatus,
  output faultStrobe_t strobe
);

  sdSrc_e srcSel;
  logic   sigDetect;
  logic   linkNext;

  assign srcSel = sdSrc_e'(sdSel);

  always_comb begin
    case (srcSel)
      SD_ACT:  sigDetect = sdAuto;
      SD_MAN:  sigDetect = sdManual;
      default: sigDetect = sdPin;
    endcase
  end

  // fiber mode: a link needs signal and no peer fault
  assign linkNext = fiberEn ? (linkIn && sigDetect && !faultSeen) : linkIn;

  always_ff @(posedge clk) begin
    if (!rstN) linkStatus <= 1'b0;
    else       linkStatus <= linkNext;
  end

  assign strobe.txReq = fiberEn && !linkStatus;
  assign strobe.detEn = fiberEn;

endmodule

// File: rtl/farend_fault_dp.sv
module farend_fault_dp
  import farend_fault_pkg::*;
#(
  parameter int ONES_LEN = 84,
  parameter int CONFIRM  = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  faultStrobe_t strobe,
  input  logic         txDataIn,
  input  logic         rxDataIn,
  output logic         txDataOut,
  output logic         txFaultActive,
  output logic         faultDetected
);

  localparam int CYCLE_LEN = ONES_LEN + 1;
  localparam int PH_W      = $clog2(CYCLE_LEN);
  localparam int RUN_W     = $clog2(ONES_LEN + 2);
  localparam int GOOD_W    = $clog2(CONFIRM + 1);

  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(ONES_LEN);
  localparam logic [RUN_W-1:0]  RUN_FULL = RUN_W'(ONES_LEN);
  localparam logic [RUN_W-1:0]  RUN_OVER = RUN_W'(ONES_LEN + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(CONFIRM);
  localparam logic [GOOD_W-1:0] GOOD_PRE = GOOD_W'(CONFIRM - 1);

  // ---------------- transmit pattern generator ----------------
  logic            txActive;
  logic [PH_W-1:0] txPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive  <= 1'b0;
      txPhase   <= '0;
      txDataOut <= 1'b0;
    end else if (!txActive) begin
      txDataOut <= txDataIn;
      if (strobe.txReq) begin
        txActive <= 1'b1;
        txPhase  <= '0;
      end
    end else begin
      txDataOut <= (txPhase != PH_LAST);
      if (txPhase == PH_LAST) begin
        txPhase  <= '0;
        txActive <= strobe.txReq;  // only leave at a cycle boundary
      end else begin
        txPhase <= txPhase + 1'b1;
      end
    end
  end

  assign txFaultActive = txActive;

  // ---------------- receive pattern monitor ----------------
  logic [RUN_W-1:0]  onesRun;
  logic [GOOD_W-1:0] goodCycles;
  logic              faultReg;

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.detEn) begin
      onesRun    <= '0;
      goodCycles <= '0;
      faultReg   <= 1'b0;
    end else if (rxDataIn) begin
      if (onesRun >= RUN_FULL) begin
        onesRun    <= RUN_OVER;  // run too long
        goodCycles <= '0;
        faultReg   <= 1'b0;
      end else begin
        onesRun <= onesRun + 1'b1;
      end
    end else begin
      onesRun <= '0;
      if (onesRun == RUN_FULL) begin
        if (goodCycles >= GOOD_PRE) begin
          goodCycles <= GOOD_MAX;
          faultReg   <= 1'b1;
        end else begin
          goodCycles <= goodCycles + 1'b1;
        end
      end else begin
        goodCycles <= '0;  // zero in the wrong place
        faultReg   <= 1'b0;
      end
    end
  end

  assign faultDetected = faultReg;

endmodule

// File: rtl/farend_fault_unit.sv
module farend_fault_unit
  import farend_fault_pkg::*;
#(
  parameter int ONES_LEN = 84,
  parameter int CONFIRM  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fiberEn,
  input  logic [1:0] sdSel,
  input  logic       sdPin,
  input  logic       sdAuto,
  input  logic       sdManual,
  input  logic       linkIn,
  input  logic       txDataIn,
  input  logic       rxDataIn,
  output logic       txDataOut,
  output logic       txFaultActive,
  output logic       faultDetected,
  output logic       linkStatus
);

  faultStrobe_t strobe;

  farend_fault_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fiberEn    (fiberEn),
    .sdSel      (sdSel),
    .sdPin      (sdPin),
    .sdAuto     (sdAuto),
    .sdManual   (sdManual),
    .linkIn     (linkIn),
    .faultSeen  (faultDetected),
    .linkStatus (linkStatus),
    .strobe     (strobe)
  );

  farend_fault_dp #(
    .ONES_LEN (ONES_LEN),
    .CONFIRM  (CONFIRM)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .txDataIn      (txDataIn),
    .rxDataIn      (rxDataIn),
    .txDataOut     (txDataOut),
    .txFaultActive (txFaultActive),
    .faultDetected (faultDetected)
  );

endmodule

// File: rtl/farend_fault_chk.sv
module farend_fault_chk (
  input logic clk,
  input logic rstN,
  input logic fiberEn,
  input logic txDataIn,
  input logic rxDataIn,
  input logic txDataOut,
  input logic txFaultActive,
  input logic faultDetected,
  input logic linkStatus
);

  a_r10_fault_drops_link: assert property (@(posedge clk) disable iff (!rstN)
    fiberEn && faultDetected |=> !linkStatus);

  a_r4_down_starts_tx: assert property (@(posedge clk) disable iff (!rstN)
    fiberEn && !linkStatus |=> txFaultActive);

  a_r6_idle_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !txFaultActive |=> txDataOut == $past(txDataIn));

  a_r5_end_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFaultActive) |-> !txDataOut);

  a_r7_set_on_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultDetected) |-> !$past(rxDataIn));

  a_r11_off_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    !fiberEn |=> !faultDetected);

endmodule

bind farend_fault_unit farend_fault_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .fiberEn       (fiberEn),
  .txDataIn      (txDataIn),
  .rxDataIn      (rxDataIn),
  .txDataOut     (txDataOut),
  .txFaultActive (txFaultActive),
  .faultDetected (faultDetected),
  .linkStatus    (linkStatus)
);

// File: tb/farend_fault_unit_tb.sv
module farend_fault_unit_tb;

  localparam int ONES = 84;
  localparam int CYC  = ONES + 1;

  logic clk = 1'b0;
  logic rstN, fiberEn, sdPin, sdAuto, sdManual, linkIn, txDataIn, rxDataIn;
  logic [1:0] sdSel;
  logic txDataOut, txFaultActive, faultDetected, linkStatus;

  int   nChecks = 0;
  int   nFails  = 0;
  logic lastIn  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  farend_fault_unit u_dut (
    .clk(clk), .rstN(rstN), .fiberEn(fiberEn), .sdSel(sdSel),
    .sdPin(sdPin), .sdAuto(sdAuto), .sdManual(sdManual), .linkIn(linkIn),
    .txDataIn(txDataIn), .rxDataIn(rxDataIn), .txDataOut(txDataOut),
    .txFaultActive(txFaultActive), .faultDetected(faultDetected),
    .linkStatus(linkStatus)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic r);
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    txDataIn = lfsr[0];
    rxDataIn = r;
    @(negedge clk);
    lastIn = txDataIn;
  endtask

  function automatic logic patt(input int j);
    return (j % CYC) != ONES;
  endfunction

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      if (!txFaultActive && linkStatus) break;
      tick(1'b0);
    end
    tick(1'b0);
  endtask

  task automatic sendCycle(input int ones);
    for (int i = 0; i < ones; i++) tick(1'b1);
    tick(1'b0);
  endtask

  task automatic setSrc(input int mode, input logic v);
    case (mode)
      0, 3: sdPin = v;
      1: sdAuto = v;
      2: sdManual = v;
      default: linkIn = v;
    endcase
  endtask

  // mode 0..3: sdSel=mode, drop that source; mode 4: drop linkIn
  task automatic runTxFault(input int mode);
    sdSel = (mode == 4) ? 2'd0 : 2'(mode);
    waitIdle();
    setSrc(mode, 1'b0);
    tick(1'b0);
    chk(mode == 4 ? "R3 link drop" : "R2 source drop", linkStatus, 1'b0);
    chk("R4 start lag", txFaultActive, 1'b0);
    tick(1'b0);
    chk("R4 active", txFaultActive, 1'b1);
    chk("R6 last data bit", txDataOut, lastIn);
    for (int j = 0; j < 2 * CYC + 40; j++) begin
      tick(1'b0);
      chk("R4 pattern bit", txDataOut, patt(j));
    end
    setSrc(mode, 1'b1);
    for (int j = 2 * CYC + 40; j < 3 * CYC; j++) begin
      tick(1'b0);
      chk("R5 finish cycle", txDataOut, patt(j));
    end
    chk("R5 active fell", txFaultActive, 1'b0);
    chk("R3 link back", linkStatus, 1'b1);
    tick(1'b0);
    chk("R5 passthrough resumes", txDataOut, lastIn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; fiberEn = 1'b1; sdSel = 2'd0; sdPin = 1'b1; sdAuto = 1'b1;
    sdManual = 1'b1; linkIn = 1'b1; txDataIn = 1'b0; rxDataIn = 1'b0;
    @(negedge clk);
    repeat (3) tick(1'b0);
    chk("R1 faultDetected", faultDetected, 1'b0);
    chk("R1 linkStatus", linkStatus, 1'b0);
    chk("R1 txFaultActive", txFaultActive, 1'b0);
    chk("R1 txDataOut", txDataOut, 1'b0);
    rstN = 1'b1;
    waitIdle();
    chk("R3 link up", linkStatus, 1'b1);

    // R6: idle pass-through of random data
    for (int i = 0; i < 60; i++) begin
      tick(1'b0);
      chk("R6 passthrough", txDataOut, lastIn);
    end

    // R2/R4/R5: every source, plus linkIn
    for (int m = 0; m < 5; m++) runTxFault(m);

    // R2: unselected sources ignored
    sdSel = 2'd1; sdAuto = 1'b1; sdPin = 1'b0; sdManual = 1'b0;
    waitIdle();
    for (int i = 0; i < 40; i++) begin
      tick(1'b0);
      chk("R2 pin ignored under activity", linkStatus, 1'b1);
      chk("R2 no tx fault", txDataOut, lastIn);
    end
    sdSel = 2'd2; sdManual = 1'b1; sdAuto = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick(1'b0);
      chk("R2 manual high keeps link", linkStatus, 1'b1);
      chk("R2 no tx fault manual", txFaultActive, 1'b0);
    end
    sdSel = 2'd0; sdPin = 1'b1; sdAuto = 1'b1;
    waitIdle();

    // R7/R10: confirmation after three cycles
    sendCycle(ONES);
    sendCycle(ONES);
    chk("R7 not after two", faultDetected, 1'b0);
    sendCycle(ONES);
    chk("R7 set after three", faultDetected, 1'b1);
    chk("R10 link lag", linkStatus, 1'b1);
    tick(1'b1);
    chk("R10 link dropped", linkStatus, 1'b0);
    chk("R10 tx lag", txFaultActive, 1'b0);
    tick(1'b1);
    chk("R10 tx fault started", txFaultActive, 1'b1);

    // R9: over-long run
    for (int i = 2; i < ONES; i++) tick(1'b1);
    chk("R9 still set at 84 ones", faultDetected, 1'b1);
    tick(1'b1);
    chk("R9 cleared at 85th one", faultDetected, 1'b0);
    tick(1'b0);
    chk("R9 zero after long run keeps clear", faultDetected, 1'b0);

    // R8: misplaced zero sweep over all positions
    for (int p = 0; p < ONES; p++) begin
      sendCycle(ONES);
      sendCycle(ONES);
      sendCycle(ONES);
      chk("R7 reconfirm", faultDetected, 1'b1);
      sendCycle(p);
      chk("R8 early zero clears", faultDetected, 1'b0);
    end
    waitIdle();

    // R11: fiber mode off
    fiberEn = 1'b0; sdPin = 1'b0;
    tick(1'b0);
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < CYC; i++) begin
        logic lk;
        lk = lfsr[3];
        linkIn = lk;
        tick(i != ONES);
        chk("R11 no detection", faultDetected, 1'b0);
        chk("R11 passthrough", txDataOut, lastIn);
        chk("R11 link follows", linkStatus, lk);
      end
    end
    fiberEn = 1'b1; sdPin = 1'b1; linkIn = 1'b1;
    waitIdle();
    chk("R11 link restored", linkStatus, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule